// File: doc/BRIEF.md
# Single-Entry Line Writeback Buffer

This block sits in a bus interface unit. It holds one modified 32-byte data-cache line that has been pushed out of the cache, and later writes that line to memory as a burst. A line can enter the buffer for three reasons:
- a dirty line is evicted when a data-cache read misses;
- a command writes back and invalidates the whole cache;
- an external flush request arrives.

Write-throughs never pass through this block.

For an eviction, the read of the incoming line is already running on the bus when the victim is copied in. The buffer therefore holds its write until the fill reports completion. The other two causes start the write in the next cycle. While the buffer holds a line, it is also a snoopable copy of that line. Lookups come from instruction-cache misses and from external inquire cycles. A lookup that hits returns the buffered line. An inquire that hits also flags a modified hit and releases a write that is still held for a fill.

Top module: `wbb_line_buf`

## Requirements
- R1: After reset the buffer is empty: `vic_ready_o`=1, `bus_req_o`=0, and no snoop hits.
- R2: The buffer takes a victim in a cycle where `vic_valid_i` and `vic_ready_o` are both high. `vic_ready_o` is low from the next cycle until the cycle in which the last beat is acknowledged, and it is high again in the cycle after that.
- R3: A victim with cause code 0 (eviction) may be loaded while a fill is open, meaning `fill_start_i` has been seen without a later `fill_done_i`. In that case `bus_req_o` stays low until the cycle after `fill_done_i`.
- R4: A victim with cause 1 (writeback-invalidate) or cause 2 (flush) raises `bus_req_o` in the cycle after the load. So does a cause-0 victim loaded when no fill is open.
- R5: The write is 4 beats of 8 bytes, sent in ascending order.
  - Beat k carries byte address line*32+8k and data bits [64k+63:64k] of the stored line.
  - `bus_last_o` is high on beat 3.
  - A beat stays on the outputs, unchanged, until `bus_ack_i` is high.
- R6: A lookup with `snp_valid_i` hits when the buffer is full and `snp_line_i` equals the stored line address. A hit drives the stored line on `snp_data_o`. A miss drives zero and `snp_hit_o`=0.
- R7: `snp_hitm_o` is high only for a hit whose source `snp_src_i` is 1 (inquire). Source 0 (instruction-cache miss) never raises it.
- R8: An inquire hit on a write still held for a fill raises `bus_req_o` in the next cycle, even though the fill has not completed.
- R9: The line still answers lookups in the cycle its last beat is acknowledged.
- R10: A victim offered while the buffer is full has no effect. The stored line and address are unchanged.
- R11: If `fill_done_i` arrives in the same cycle as a cause-0 load, the write is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vic_valid_i | input | 1 | Victim line offered |
| vic_cause_i | input | 2 | 0 eviction, 1 writeback-invalidate, 2 flush |
| vic_line_i | input | 27 | Victim line address (byte address / 32) |
| vic_data_i | input | 256 | Victim line data, byte 0 in bits [7:0] |
| vic_ready_o | output | 1 | Buffer empty, victim can be taken |
| fill_start_i | input | 1 | Line fill read started on the bus |
| fill_done_i | input | 1 | Line fill completed |
| bus_req_o | output | 1 | Burst write beat valid |
| bus_addr_o | output | 32 | Byte address of current beat |
| bus_data_o | output | 64 | Data of current beat |
| bus_last_o | output | 1 | Current beat is the final one |
| bus_ack_i | input | 1 | Current beat accepted |
| snp_valid_i | input | 1 | Snoop lookup |
| snp_src_i | input | 1 | 0 instruction-cache miss, 1 inquire |
| snp_line_i | input | 27 | Snoop line address |
| snp_hit_o | output | 1 | Lookup hits buffered line |
| snp_hitm_o | output | 1 | Inquire hit on modified data |
| snp_data_o | output | 256 | Buffered line on hit, zero otherwise |

## Verification
Two things can collide in one cycle: a snoop lookup, and the acknowledge of the final burst beat that empties the buffer. The bench arranges this by raising an inquire to the stored line together with `bus_ack_i` while `bus_last_o` is high. It expects a hit carrying the full line in that cycle, and a miss on the same lookup one cycle later. A second same-cycle case is also driven: `fill_done_i` together with an eviction load. For this case the bench expects the write request in the very next cycle.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    CAUSE_EVICT = 2'd0,
    CAUSE_WBINV = 2'd1,
    CAUSE_FLUSH = 2'd2
  } vic_cause_e;

  typedef enum logic {
    SRC_IMISS = 1'b0,
    SRC_INQ   = 1'b1
  } snp_src_e;
endpackage

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int LA_W   = 27,
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int CNT_W  = 2,
  parameter int BOFF_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [LA_W-1:0]               line_i,
  input  logic [LINE_W-1:0]             data_i,
  input  logic [CNT_W-1:0]              beat_i,
  output logic [LA_W-1:0]               line_o,
  output logic [LINE_W-1:0]             data_o,
  output logic [LA_W+CNT_W+BOFF_W-1:0]  beat_addr_o,
  output logic [BEAT_W-1:0]             beat_data_o
);
  logic [LA_W-1:0]   line_q;
  logic [LINE_W-1:0] data_q;
  logic [BEAT_W-1:0] beats [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      line_q <= line_i;
      data_q <= data_i;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beats[g] = data_q[g*BEAT_W +: BEAT_W];
  end

  assign line_o      = line_q;
  assign data_o      = data_q;
  assign beat_data_o = beats[beat_i];
  assign beat_addr_o = {line_q, beat_i, {BOFF_W{1'b0}}};
endmodule

// File: rtl/wbb_snoop.sv
module wbb_snoop #(
  parameter int LA_W   = 27,
  parameter int LINE_W = 256
) (
  input  logic              full_i,
  input  logic [LA_W-1:0]   line_i,
  input  logic [LINE_W-1:0] data_i,
  input  logic              snp_valid_i,
  input  logic              snp_src_i,
  input  logic [LA_W-1:0]   snp_line_i,
  output logic              hit_o,
  output logic              hitm_o,
  output logic [LINE_W-1:0] data_o
);
  import wbb_pkg::*;

  always_comb begin
    hit_o  = snp_valid_i && full_i && (snp_line_i == line_i);
    hitm_o = hit_o && (snp_src_e'(snp_src_i) == SRC_INQ);
    data_o = hit_o ? data_i : '0;
  end
endmodule

// File: rtl/wbb_ctrl.sv
module wbb_ctrl #(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vic_valid_i,
  input  wbb_pkg::vic_cause_e cause_i,
  input  logic              fill_start_i,
  input  logic              fill_done_i,
  input  logic              inq_hit_i,
  input  logic              bus_ack_i,
  output logic              load_o,
  output logic              full_o,
  output logic              req_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  beat_o
);
  import wbb_pkg::*;

  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic             full_q, hold_q, fill_open_q;
  logic [CNT_W-1:0] beat_q;
  logic             hold_d, beat_go, done;

  assign load_o  = vic_valid_i && !full_q;
  assign req_o   = full_q && !hold_q;
  assign last_o  = beat_q == LAST_BEAT;
  assign beat_go = req_o && bus_ack_i;
  assign done    = beat_go && last_o;
  // eviction waits only for a fill still open after this cycle
  assign hold_d  = (cause_i == CAUSE_EVICT) && fill_open_q && !fill_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_open_q <= 1'b0;
    end else if (fill_start_i) begin
      fill_open_q <= 1'b1;
    end else if (fill_done_i) begin
      fill_open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= 1'b0;
      beat_q <= '0;
    end else if (load_o) begin
      full_q <= 1'b1;
      hold_q <= hold_d;
      beat_q <= '0;
    end else begin
      if (done) full_q <= 1'b0;
      if (fill_done_i || inq_hit_i) hold_q <= 1'b0;
      if (beat_go) beat_q <= last_o ? '0 : beat_q + 1'b1;
    end
  end

  assign full_o = full_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/wbb_line_buf.sv
module wbb_line_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BOFF_W    = $clog2(BEAT_BYTES),
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int CNT_W     = OFF_W - BOFF_W,
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int BEAT_W    = BEAT_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vic_valid_i,
  input  logic [1:0]        vic_cause_i,
  input  logic [LA_W-1:0]   vic_line_i,
  input  logic [LINE_W-1:0] vic_data_i,
  output logic              vic_ready_o,
  input  logic              fill_start_i,
  input  logic              fill_done_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BEAT_W-1:0] bus_data_o,
  output logic              bus_last_o,
  input  logic              bus_ack_i,
  input  logic              snp_valid_i,
  input  logic              snp_src_i,
  input  logic [LA_W-1:0]   snp_line_i,
  output logic              snp_hit_o,
  output logic              snp_hitm_o,
  output logic [LINE_W-1:0] snp_data_o
);
  import wbb_pkg::*;

  logic              load, full;
  logic [CNT_W-1:0]  beat;
  logic [LA_W-1:0]   line_q;
  logic [LINE_W-1:0] data_q;

  wbb_ctrl #(.BEATS(BEATS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vic_valid_i (vic_valid_i),
    .cause_i     (vic_cause_e'(vic_cause_i)),
    .fill_start_i(fill_start_i),
    .fill_done_i (fill_done_i),
    .inq_hit_i   (snp_hitm_o),
    .bus_ack_i   (bus_ack_i),
    .load_o      (load),
    .full_o      (full),
    .req_o       (bus_req_o),
    .last_o      (bus_last_o),
    .beat_o      (beat)
  );

  wbb_store #(
    .LA_W(LA_W), .LINE_W(LINE_W), .BEAT_W(BEAT_W),
    .BEATS(BEATS), .CNT_W(CNT_W), .BOFF_W(BOFF_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .line_i     (vic_line_i),
    .data_i     (vic_data_i),
    .beat_i     (beat),
    .line_o     (line_q),
    .data_o     (data_q),
    .beat_addr_o(bus_addr_o),
    .beat_data_o(bus_data_o)
  );

  wbb_snoop #(.LA_W(LA_W), .LINE_W(LINE_W)) u_snoop (
    .full_i     (full),
    .line_i     (line_q),
    .data_i     (data_q),
    .snp_valid_i(snp_valid_i),
    .snp_src_i  (snp_src_i),
    .snp_line_i (snp_line_i),
    .hit_o      (snp_hit_o),
    .hitm_o     (snp_hitm_o),
    .data_o     (snp_data_o)
  );

  assign vic_ready_o = !full;
endmodule

// File: rtl/wbb_line_buf_chk.sv
module wbb_line_buf_chk #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vic_ready_o,
  input logic              fill_done_i,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BEAT_W-1:0] bus_data_o,
  input logic              bus_last_o,
  input logic              bus_ack_i,
  input logic              snp_src_i,
  input logic              snp_hit_o,
  input logic              snp_hitm_o
);
  a_r1_no_hit_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_ready_o |-> !snp_hit_o);

  a_r2_stay_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vic_ready_o && !(bus_req_o && bus_ack_i && bus_last_o) |=> !vic_ready_o);

  a_r2_free_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_last_o |=> vic_ready_o);

  a_r4_req_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !vic_ready_o);

  a_r3_hold_until_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vic_ready_o && !bus_req_o && !fill_done_i && !snp_hitm_o |=> !bus_req_o);

  a_r5_beat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_data_o) && $stable(bus_last_o));

  a_r7_hitm_is_inquire_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hitm_o |-> snp_hit_o && snp_src_i);

  a_r8_inquire_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hitm_o && !bus_req_o && !vic_ready_o |=> bus_req_o);
endmodule

bind wbb_line_buf wbb_line_buf_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vic_ready_o(vic_ready_o),
  .fill_done_i(fill_done_i),
  .bus_req_o  (bus_req_o),
  .bus_addr_o (bus_addr_o),
  .bus_data_o (bus_data_o),
  .bus_last_o (bus_last_o),
  .bus_ack_i  (bus_ack_i),
  .snp_src_i  (snp_src_i),
  .snp_hit_o  (snp_hit_o),
  .snp_hitm_o (snp_hitm_o)
);

// File: tb/wbb_line_buf_bench.sv
module wbb_line_buf_bench;
  localparam int CLK_P = 10;

  logic clk_i = 1'b0;
  always #(CLK_P/2) clk_i = ~clk_i;

  logic         rst_ni = 1'b0;
  logic         vic_valid_i = 0, fill_start_i = 0, fill_done_i = 0, bus_ack_i = 0;
  logic         snp_valid_i = 0, snp_src_i = 0;
  logic [1:0]   vic_cause_i = 0;
  logic [26:0]  vic_line_i = 0, snp_line_i = 0;
  logic [255:0] vic_data_i = 0;
  logic         vic_ready_o, bus_req_o, bus_last_o, snp_hit_o, snp_hitm_o;
  logic [31:0]  bus_addr_o;
  logic [63:0]  bus_data_o;
  logic [255:0] snp_data_o;

  wbb_line_buf u_wbb_line_buf (.*);

  int    n_cmp = 0, n_bad = 0;
  bit    fin = 0;
  string cur = "R1";

  // reference model
  bit          m_full = 0, m_hold = 0, m_fopen = 0;
  int          m_beat = 0;
  logic [26:0] m_line = 0;
  logic [7:0]  m_bytes[$];

  function automatic logic [255:0] mk_line(int s);
    logic [255:0] l;
    for (int i = 0; i < 32; i++) l[8*i +: 8] = 8'(s*37 + i*11 + 1);
    return l;
  endfunction

  function automatic logic [255:0] m_pack();
    logic [255:0] l = '0;
    for (int i = 0; i < m_bytes.size(); i++) l[8*i +: 8] = m_bytes[i];
    return l;
  endfunction

  task automatic cmp(string tag, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, cur, act, exp);
    end
  endtask

  task automatic cyc();
    logic         e_req, e_hit, ld;
    logic [255:0] ml;
    #1;
    ml    = m_pack();
    e_req = m_full && !m_hold;
    e_hit = snp_valid_i && m_full && (snp_line_i == m_line);
    cmp("R1 R2 ready", 256'(vic_ready_o), 256'(!m_full));
    cmp("R3 R4 R8 R11 req", 256'(bus_req_o), 256'(e_req));
    if (e_req) begin
      cmp("R5 addr", 256'(bus_addr_o), 256'({m_line, 5'b0} + 32'(8*m_beat)));
      cmp("R5 data", 256'(bus_data_o), 256'(ml[64*m_beat +: 64]));
      cmp("R5 last", 256'(bus_last_o), 256'(m_beat == 3));
    end
    cmp("R6 R9 hit", 256'(snp_hit_o), 256'(e_hit));
    cmp("R7 hitm", 256'(snp_hitm_o), 256'(e_hit && snp_src_i));
    cmp("R6 snoop data", snp_data_o, e_hit ? ml : '0);
    @(posedge clk_i);
    if (!rst_ni) begin
      m_full = 0; m_hold = 0; m_fopen = 0; m_beat = 0; m_line = 0; m_bytes = {};
    end else begin
      ld = vic_valid_i && !m_full;
      if (ld) begin
        m_full = 1; m_beat = 0; m_line = vic_line_i; m_bytes = {};
        for (int i = 0; i < 32; i++) m_bytes.push_back(vic_data_i[8*i +: 8]);
        m_hold = (vic_cause_i == 2'd0) && m_fopen && !fill_done_i;
      end else begin
        if (e_req && bus_ack_i) begin
          if (m_beat == 3) begin m_full = 0; m_beat = 0; end
          else m_beat++;
        end
        if (fill_done_i || (e_hit && snp_src_i)) m_hold = 0;
      end
      if (fill_start_i) m_fopen = 1;
      else if (fill_done_i) m_fopen = 0;
    end
    @(negedge clk_i);
    vic_valid_i = 0; fill_start_i = 0; fill_done_i = 0; bus_ack_i = 0; snp_valid_i = 0;
  endtask

  task automatic load(logic [1:0] c, logic [26:0] ln, int s);
    vic_valid_i = 1; vic_cause_i = c; vic_line_i = ln; vic_data_i = mk_line(s);
    cyc();
  endtask

  task automatic drain(int gap);
    for (int k = 0; k < 40 && m_full; k++) begin
      bus_ack_i = (gap == 0) || (k % gap == 0);
      cyc();
    end
  endtask

  task automatic snoop(logic src, logic [26:0] ln);
    snp_valid_i = 1; snp_src_i = src; snp_line_i = ln;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    @(negedge clk_i);
    cur = "R1";
    repeat (3) cyc();
    rst_ni = 1;
    cyc();

    cur = "R4 flush";
    load(2'd2, 27'h80, 1);
    snoop(0, 27'h80); cyc();             // R7: icache hit, no hitm
    snoop(1, 27'h81); cyc();             // R6: miss
    drain(2);

    cur = "R3 evict held";
    fill_start_i = 1; cyc();
    load(2'd0, 27'h123, 2);
    cyc(); snoop(1, 27'h124); cyc(); cyc();
    fill_done_i = 1; cyc();
    drain(0);

    cur = "R8 inquire release";
    fill_start_i = 1; cyc();
    load(2'd0, 27'h200, 3);
    cyc();
    snoop(1, 27'h200); cyc();
    drain(0);
    fill_done_i = 1; cyc();

    cur = "R10 full ignores load";
    load(2'd1, 27'h300, 4);
    vic_valid_i = 1; vic_cause_i = 2'd2; vic_line_i = 27'h301; vic_data_i = mk_line(9);
    cyc();
    snoop(0, 27'h300); cyc();
    snoop(0, 27'h301); cyc();
    drain(3);

    cur = "R9 snoop on last ack";
    load(2'd2, 27'h44, 5);
    bus_ack_i = 1; cyc(); bus_ack_i = 1; cyc(); bus_ack_i = 1; cyc();
    bus_ack_i = 1; snoop(1, 27'h44); cyc();
    snoop(1, 27'h44); cyc();

    cur = "R11 fill done with load";
    fill_start_i = 1; cyc();
    fill_done_i = 1;
    load(2'd0, 27'h77, 6);
    drain(0);

    cur = "R4 evict no fill";
    load(2'd0, 27'h55, 7);
    drain(0);

    cur = "R2 back to back";
    load(2'd1, 27'h66, 8);
    drain(0);
    load(2'd2, 27'h67, 10);
    drain(1);
    cyc(); cyc();

    fin = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog [%s] actual=running expected=finished", cur);
      summary();
      $finish;
    end
  end
endmodule